// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This bridge lets a management agent with only 16-bit register access reach a 32-bit internal register space. One PHY address is set aside for the bridge. At that address, register 31 holds a 10-bit page that supplies internal address bits 15:6. Registers 0 to 15 choose the word inside the page (address bits 5:2) and carry the low half of the data. Register 16 carries the high half. The serial management framing is decoded elsewhere. The bridge sees single-cycle read and write strobes, together with the PHY address, the register number and the write data.

A 32-bit read starts with a low-half access. That access performs the internal read and holds the upper half, so a later register 16 read returns upper bits from the same internal read. A 32-bit write works the other way round. The low half is buffered with its word index, and the register 16 write then commits the whole word in one internal write. The internal bus is a simple strobe interface: the read data must be valid in the same cycle as the read strobe.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset the page, the buffered low half, the held high half and `mdio_rdata` are zero, and `mdio_rvalid`, `bus_rd` and `bus_wr` are low.
- R2: A write to register 31 at the bridge's PHY address (default 31) stores `mdio_wdata[9:0]` as the page. A read of register 31 returns `{6'b0, page}`.
- R3: A read of register r (0 to 15) asserts `bus_rd` in the same cycle with `bus_addr = {page, r[3:0], 2'b00}`. In the next cycle `mdio_rvalid` is high and `mdio_rdata` equals `bus_rdata[15:0]`.
- R4: A read of register 16 makes no bus access. One cycle later it returns `bus_rdata[31:16]` as held by the most recent low-half read.
- R5: A write to register r (0 to 15) makes no bus access. It buffers the data and r[3:0].
- R6: A write to register 16 asserts `bus_wr` in the same cycle with `bus_addr = {page, buffered r[3:0], 2'b00}` and `bus_wdata = {mdio_wdata, buffered low half}`.
- R7: Strobes at any other PHY address cause no bus strobe and no `mdio_rvalid`, and they leave the page and the held high half unchanged.
- R8: A read of registers 17 to 30 returns zero with `mdio_rvalid` and makes no bus access.
- R9: When read and write strobes come in the same cycle, only the write is carried out. There is no `mdio_rvalid` and no `bus_rd`.
- R10: The commit address uses the page in force at the register 16 write, even if the page changed after the low-half write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdio_rd | input | 1 | Decoded register read strobe |
| mdio_wr | input | 1 | Decoded register write strobe |
| mdio_phy | input | 5 | PHY address of the access |
| mdio_reg | input | 5 | Register number of the access |
| mdio_wdata | input | 16 | Register write data |
| mdio_rdata | output | 16 | Register read data |
| mdio_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| bus_rd | output | 1 | Internal read strobe |
| bus_wr | output | 1 | Internal write strobe |
| bus_addr | output | 16 | Internal byte address |
| bus_wdata | output | 32 | Internal write data |
| bus_rdata | input | 32 | Internal read data, valid with `bus_rd` |

## Verification
Two of the bridge's functions can fall in the same cycle: a register read and a register write. The bench raises both strobes together while the write targets the page register. It then judges the outcome in two ways. It checks that neither `mdio_rvalid` nor `bus_rd` appears. It also reads the page back and checks that the write took effect. A related ordering case changes the page between a low-half write and its register 16 commit, and the scoreboard expects the commit at the new page.

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge #(
  parameter int PHY_ID   = 31,
  parameter int PAGE_REG = 31,
  parameter int HIGH_REG = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mdio_rd,
  input  logic        mdio_wr,
  input  logic [4:0]  mdio_phy,
  input  logic [4:0]  mdio_reg,
  input  logic [15:0] mdio_wdata,
  output logic [15:0] mdio_rdata,
  output logic        mdio_rvalid,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [15:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata
);
  logic [9:0]  page_q;
  logic [3:0]  word_q;
  logic [15:0] lo_q;
  logic [15:0] hi_q;

  logic hit, wr_en, rd_en, is_low, is_high, is_page;
  assign hit     = (mdio_phy == 5'(PHY_ID));
  assign wr_en   = hit & mdio_wr;
  assign rd_en   = hit & mdio_rd & ~mdio_wr;
  assign is_low  = ~mdio_reg[4];
  assign is_high = (mdio_reg == 5'(HIGH_REG));
  assign is_page = (mdio_reg == 5'(PAGE_REG));

  assign bus_rd    = rd_en & is_low;
  assign bus_wr    = wr_en & is_high;
  assign bus_addr  = {page_q, (bus_wr ? word_q : mdio_reg[3:0]), 2'b00};
  assign bus_wdata = {mdio_wdata, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q      <= '0;
      word_q      <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      mdio_rdata  <= '0;
      mdio_rvalid <= 1'b0;
    end else begin
      mdio_rvalid <= rd_en;
      if (wr_en) begin
        if (is_page) page_q <= mdio_wdata[9:0];
        else if (is_low) begin
          lo_q   <= mdio_wdata;
          word_q <= mdio_reg[3:0];
        end
      end
      if (rd_en) begin
        if (is_low) begin
          mdio_rdata <= bus_rdata[15:0];
          hi_q       <= bus_rdata[31:16];
        end else if (is_high) mdio_rdata <= hi_q;
        else if (is_page)     mdio_rdata <= {6'b0, page_q};
        else                  mdio_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk #(
  parameter int PHY_ID = 31
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mdio_rd,
  input logic        mdio_wr,
  input logic [4:0]  mdio_phy,
  input logic [4:0]  mdio_reg,
  input logic [15:0] mdio_wdata,
  input logic [15:0] mdio_rdata,
  input logic        mdio_rvalid,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [9:0]  page_q
);
  logic hit;
  assign hit = (mdio_phy == 5'(PHY_ID));

  p_rvalid_follows_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mdio_rd && !mdio_wr) |=> mdio_rvalid);
  p_low_read_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (mdio_rdata == $past(bus_rdata[15:0])));
  p_commit_high_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_wdata[31:16] == mdio_wdata));
  p_foreign_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!bus_rd && !bus_wr));
  p_foreign_page_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(page_q));
  p_quiet_without_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && mdio_rd) |=> !mdio_rvalid);
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));
endmodule

bind mdio_page_bridge mdio_page_bridge_chk #(.PHY_ID(PHY_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_rd(mdio_rd), .mdio_wr(mdio_wr),
  .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
  .mdio_rdata(mdio_rdata), .mdio_rvalid(mdio_rvalid), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .page_q(page_q)
);

// File: tb/mdio_page_bridge_test.sv
module mdio_page_bridge_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mdio_rd = 0, mdio_wr = 0;
  logic [4:0]  mdio_phy = 0, mdio_reg = 0;
  logic [15:0] mdio_wdata = 0;
  logic [15:0] mdio_rdata;
  logic        mdio_rvalid, bus_rd, bus_wr;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] q_rd[$];
  string       q_rd_tag[$];
  logic [48:0] q_bus[$];
  string       q_bus_tag[$];

  always #10 clk = ~clk;

  function automatic logic [31:0] model(input logic [15:0] a);
    return {a ^ 16'hA5C3, a + 16'h1111};
  endfunction
  assign bus_rdata = model(bus_addr);

  mdio_page_bridge uut (
    .clk(clk), .rst_n(rst_n), .mdio_rd(mdio_rd), .mdio_wr(mdio_wr),
    .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
    .mdio_rdata(mdio_rdata), .mdio_rvalid(mdio_rvalid), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] addr_of(input logic [9:0] pg, input logic [3:0] w);
    return {pg, w, 2'b00};
  endfunction

  task automatic op(input bit rd, input bit wr, input logic [4:0] phy,
                    input logic [4:0] rg, input logic [15:0] wd,
                    input bit exp_rv, input logic [15:0] exp_data,
                    input bit exp_bus, input logic [48:0] exp_item, input string tag);
    @(posedge clk); #5;
    mdio_rd = rd; mdio_wr = wr; mdio_phy = phy; mdio_reg = rg; mdio_wdata = wd;
    if (exp_rv)  begin q_rd.push_back(exp_data); q_rd_tag.push_back(tag); end
    if (exp_bus) begin q_bus.push_back(exp_item); q_bus_tag.push_back(tag); end
    @(posedge clk); #5;
    mdio_rd = 0; mdio_wr = 0;
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (bus_rd || bus_wr) begin
      if (q_bus.size() == 0) check("unexpected bus strobe R7", {bus_wr, bus_addr}, 0);
      else begin
        logic [48:0] e;
        string t;
        e = q_bus.pop_front(); t = q_bus_tag.pop_front();
        if (e[48]) check(t, {bus_wr, bus_addr, bus_wdata}, e);
        else       check(t, {bus_wr, bus_addr}, {e[48], e[47:32]});
      end
    end
    if (mdio_rvalid) begin
      if (q_rd.size() == 0) check("unexpected rvalid R7 R9", mdio_rdata, 0);
      else check(q_rd_tag.pop_front(), mdio_rdata, q_rd.pop_front());
    end
  end

  initial begin
    #(20 * 5000);
    check("watchdog", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] m;
    repeat (3) @(posedge clk);
    #5;
    check("R1 rdata", mdio_rdata, 0);
    check("R1 strobes", {mdio_rvalid, bus_rd, bus_wr}, 0);
    rst_n = 1;
    // R1: held high half is zero after reset
    op(1, 0, 31, 16, 0, 1, 16'h0000, 0, 0, "R1 high half");
    // R2: page write keeps bits 9:0
    op(0, 1, 31, 31, 16'hFFA5, 0, 0, 0, 0, "R2 write");
    op(1, 0, 31, 31, 0, 1, 16'h03A5, 0, 0, "R2 readback");
    // R3 / R4
    m = model(addr_of(10'h3A5, 4'd5));
    op(1, 0, 31, 5, 0, 1, m[15:0], 1, {1'b0, addr_of(10'h3A5, 4'd5), 32'h0}, "R3 low read");
    op(1, 0, 31, 16, 0, 1, m[31:16], 0, 0, "R4 high read");
    m = model(addr_of(10'h3A5, 4'd15));
    op(1, 0, 31, 15, 0, 1, m[15:0], 1, {1'b0, addr_of(10'h3A5, 4'd15), 32'h0}, "R3 word 15");
    // R5 / R6
    op(0, 1, 31, 9, 16'h1234, 0, 0, 0, 0, "R5 low write");
    op(0, 1, 31, 16, 16'hABCD, 0, 0, 1, {1'b1, addr_of(10'h3A5, 4'd9), 32'hABCD1234}, "R6 commit");
    // R7: foreign PHY
    op(0, 1, 3, 31, 16'h0001, 0, 0, 0, 0, "R7 foreign write");
    op(1, 0, 3, 5, 0, 0, 0, 0, 0, "R7 foreign read");
    op(0, 1, 30, 16, 16'h9999, 0, 0, 0, 0, "R7 foreign commit");
    op(1, 0, 31, 31, 0, 1, 16'h03A5, 0, 0, "R7 page kept");
    op(1, 0, 31, 16, 0, 1, m[31:16], 0, 0, "R7 high half kept");
    // R8
    op(1, 0, 31, 20, 0, 1, 16'h0000, 0, 0, "R8 reg 20");
    op(1, 0, 31, 17, 0, 1, 16'h0000, 0, 0, "R8 reg 17");
    // R9: both strobes, write wins
    op(1, 1, 31, 31, 16'h0011, 0, 0, 0, 0, "R9 both");
    op(1, 0, 31, 31, 0, 1, 16'h0011, 0, 0, "R9 page written");
    op(1, 1, 31, 4, 16'h4444, 0, 0, 0, 0, "R9 both low");
    op(0, 1, 31, 16, 16'h2222, 0, 0, 1, {1'b1, addr_of(10'h011, 4'd4), 32'h22224444}, "R9 low buffered");
    // R10: page change between halves
    op(0, 1, 31, 2, 16'h5555, 0, 0, 0, 0, "R10 low write");
    op(0, 1, 31, 31, 16'h00FF, 0, 0, 0, 0, "R10 page change");
    op(0, 1, 31, 16, 16'h7777, 0, 0, 1, {1'b1, addr_of(10'h0FF, 4'd2), 32'h77775555}, "R10 commit");
    m = model(addr_of(10'h0FF, 4'd0));
    op(1, 0, 31, 0, 0, 1, m[15:0], 1, {1'b0, addr_of(10'h0FF, 4'd0), 32'h0}, "R3 new page");
    op(1, 0, 31, 16, 0, 1, m[31:16], 0, 0, "R4 new page");
    repeat (3) @(posedge clk);
    #5;
    check("R7 no pending reads", q_rd.size(), 0);
    check("R6 no pending bus", q_bus.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule